// File: doc/BRIEF.md
# Dual-Input Pixel Vector Packer

The packer gathers shaded-pixel candidates from two rasterizer streams, called A and B, and groups them into eight-lane vectors for a downstream shader scheduler. Each stream presents at most one pixel per clock. A pixel is a cache address and an interpolated colour, qualified by a valid flag. Pixels fill lanes in arrival order. When both streams deliver in the same clock, A goes first. When the eighth lane fills, the vector leaves on the next clock edge with a lane-valid mask.

Sometimes both streams deliver while only one lane is free. A's pixel then closes the current vector and B's pixel opens the next one in lane 0. Rasterizer traffic can stop partway through a vector, so an inactivity countdown of 32 clocks flushes a partial vector with only its filled lanes marked in the mask. While the scheduler has no free slot it raises a stall input. During a stall the packer freezes: it takes no pixels, emits nothing and pauses its countdown.

The control is a two-state machine with the states `ST_EMPTY` (no lanes held, countdown idle) and `ST_PARTIAL` (1 to 7 lanes held, countdown running). Its transitions are:
- `ST_EMPTY` to `ST_PARTIAL` on the first accepted pixel (start).
- `ST_PARTIAL` to `ST_PARTIAL` when more pixels arrive without completing the vector (grow), or when A completes the vector and B spills into the next one (spill).
- `ST_PARTIAL` to `ST_EMPTY` when arrivals exactly complete the vector (complete), or when the countdown expires (flush).
- Either state holds during a stall (freeze).

Top module: `pix_vec_packer`

## Requirements
- R1: After reset no vector is output (`out_vld` low), the packer holds no lanes and the countdown is idle. The first eight pixels accepted after reset therefore form exactly one full vector.
- R2: When the eighth lane fills, `out_vld` is high for one cycle on the next clock edge and `out_mask` is 8'hFF.
- R3: When A and B are both valid and at least two lanes are free, A's pixel takes the lower lane index and B's pixel takes the next one.
- R4: When the arriving pixels (A only, B only, or both) exactly fill the last free lanes, the vector is emitted and the next vector starts empty at lane 0.
- R5: When A and B are both valid and exactly one lane is free, A's pixel completes the emitted vector and B's pixel becomes lane 0 of the next vector, which then holds one pixel.
- R6: If no pixel is accepted for 32 consecutive unstalled clocks while 1 to 7 lanes are held, the partial vector is emitted on the 32nd such clock edge. Its mask bit i is set exactly for the filled lanes i = 0 .. count-1.
- R7: Every accepted pixel restarts the countdown at its full 32-clock length.
- R8: When the packer holds no lanes, idle clocks emit nothing, however long they last.
- R9: While `stall_i` is high, valid inputs are not accepted, no vector is emitted, and the lane count and the countdown keep their values.
- R10: Lane i of an emitted vector carries, in `out_addr[16*i +: 16]` and `out_color[16*i +: 16]`, the address and colour of the pixel placed in lane i. The set mask bits always form a contiguous run starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Downstream has no free slot; freeze the packer |
| a_vld | input | 1 | Stream A pixel valid |
| a_addr | input | 16 | Stream A cache address |
| a_color | input | 16 | Stream A interpolated colour |
| b_vld | input | 1 | Stream B pixel valid |
| b_addr | input | 16 | Stream B cache address |
| b_color | input | 16 | Stream B interpolated colour |
| out_vld | output | 1 | Vector valid, one-cycle pulse |
| out_mask | output | 8 | Lane-valid mask, bit i for lane i |
| out_addr | output | 128 | Lane addresses, lane i at bits 16*i+15:16*i |
| out_color | output | 128 | Lane colours, lane i at bits 16*i+15:16*i |

## Verification
The following properties are checked on every cycle:
- A stall is followed by no emission and an unchanged lane count.
- An emitted mask is never empty and always forms a prefix run.
- The empty state always holds zero lanes.
- A two-pixel arrival into the last free lane yields a full vector and a one-pixel carry.
- A partial vector only appears after a clock with no arrivals.

Only the scoreboard scenarios can show the rest:
- the exact lane each pixel's address and colour lands in;
- the 32-clock flush latency, and its restart by late pixels;
- the absence of any output while the packer idles empty or stalls with pixels pending.

// File: rtl/pvp_pkg.sv
package pvp_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY   = 1'b0,
        ST_PARTIAL = 1'b1
    } pvp_state_e;
endpackage

// File: rtl/pvp_lane_steer.sv
// Decides which lane each incoming pixel lands in, whether B spills into a
// new vector, and the lane total after this clock's arrivals.
module pvp_lane_steer #(
    parameter int LANES = 8,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [CW-1:0]    fill,
    input  logic             a_take,
    input  logic             b_take,
    output logic [LANES-1:0] sel_a,
    output logic [LANES-1:0] sel_b,
    output logic             spill,
    output logic [CW:0]      total
);
    logic [CW:0] pos_a;
    logic [CW:0] pos_b;

    assign pos_a = {1'b0, fill};
    assign pos_b = pos_a + {{CW{1'b0}}, a_take};
    assign total = pos_b + {{CW{1'b0}}, b_take};
    assign spill = b_take && (pos_b == (CW+1)'(LANES));

    for (genvar i = 0; i < LANES; i++) begin : g_sel
        assign sel_a[i] = a_take && (pos_a == (CW+1)'(i));
        assign sel_b[i] = b_take && (pos_b == (CW+1)'(i));
    end
endmodule

// File: rtl/pvp_idle_timer.sv
// Inactivity countdown: reloads on an accepted pixel, counts down on idle
// clocks, and reports expiry when it has reached zero.
module pvp_idle_timer #(
    parameter int TIMEOUT = 32,
    parameter int TW      = $clog2(TIMEOUT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (load) begin
            tmr_q <= TW'(TIMEOUT - 1);
        end else if (tick && (tmr_q != '0)) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign expired = (tmr_q == '0);
endmodule

// File: rtl/pvp_lane_store.sv
// Per-lane pixel storage. The merged view overlays this clock's arrivals on
// the held lanes; on a spill, lane 0 is reloaded with B's pixel.
module pvp_lane_store #(
    parameter int LANES   = 8,
    parameter int ADDR_W  = 16,
    parameter int COLOR_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           sel_a,
    input  logic [LANES-1:0]           sel_b,
    input  logic                       spill,
    input  logic [ADDR_W-1:0]          a_addr,
    input  logic [COLOR_W-1:0]         a_color,
    input  logic [ADDR_W-1:0]          b_addr,
    input  logic [COLOR_W-1:0]         b_color,
    output logic [LANES*ADDR_W-1:0]    merged_addr,
    output logic [LANES*COLOR_W-1:0]   merged_color
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0]  addr_q;
        logic [COLOR_W-1:0] color_q;
        logic [ADDR_W-1:0]  addr_m;
        logic [COLOR_W-1:0] color_m;

        always_comb begin
            addr_m  = addr_q;
            color_m = color_q;
            if (sel_a[i]) begin
                addr_m  = a_addr;
                color_m = a_color;
            end else if (sel_b[i]) begin
                addr_m  = b_addr;
                color_m = b_color;
            end
        end

        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q  <= '0;
                    color_q <= '0;
                end else if (spill) begin
                    addr_q  <= b_addr;
                    color_q <= b_color;
                end else begin
                    addr_q  <= addr_m;
                    color_q <= color_m;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q  <= '0;
                    color_q <= '0;
                end else begin
                    addr_q  <= addr_m;
                    color_q <= color_m;
                end
            end
        end

        assign merged_addr[i*ADDR_W +: ADDR_W]    = addr_m;
        assign merged_color[i*COLOR_W +: COLOR_W] = color_m;
    end
endmodule

// File: rtl/pix_vec_packer.sv
module pix_vec_packer #(
    parameter int LANES   = 8,
    parameter int ADDR_W  = 16,
    parameter int COLOR_W = 16,
    parameter int TIMEOUT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall_i,
    input  logic                     a_vld,
    input  logic [ADDR_W-1:0]        a_addr,
    input  logic [COLOR_W-1:0]       a_color,
    input  logic                     b_vld,
    input  logic [ADDR_W-1:0]        b_addr,
    input  logic [COLOR_W-1:0]       b_color,
    output logic                     out_vld,
    output logic [LANES-1:0]         out_mask,
    output logic [LANES*ADDR_W-1:0]  out_addr,
    output logic [LANES*COLOR_W-1:0] out_color
);
    import pvp_pkg::*;

    localparam int CW = $clog2(LANES + 1);

    pvp_state_e    state_q, state_n;
    logic [CW-1:0] fill_q, fill_n;

    logic                     a_take, b_take, any_take;
    logic [LANES-1:0]         sel_a, sel_b, mask_n;
    logic                     spill, full, expired, tick, flush, emit;
    logic [CW:0]              total;
    logic [LANES*ADDR_W-1:0]  merged_addr;
    logic [LANES*COLOR_W-1:0] merged_color;

    assign a_take   = a_vld && !stall_i;
    assign b_take   = b_vld && !stall_i;
    assign any_take = a_take || b_take;

    pvp_lane_steer #(.LANES(LANES), .CW(CW)) u_steer (
        .fill   (fill_q),
        .a_take (a_take),
        .b_take (b_take),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .spill  (spill),
        .total  (total)
    );

    assign tick  = (state_q == ST_PARTIAL) && !stall_i && !any_take;
    assign flush = tick && expired;
    assign full  = (total >= (CW+1)'(LANES));
    assign emit  = full || flush;

    pvp_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (any_take),
        .tick    (tick),
        .expired (expired)
    );

    pvp_lane_store #(.LANES(LANES), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .spill        (spill),
        .a_addr       (a_addr),
        .a_color      (a_color),
        .b_addr       (b_addr),
        .b_color      (b_color),
        .merged_addr  (merged_addr),
        .merged_color (merged_color)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign mask_n[i] = full || ((CW+1)'(i) < total);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_n;
            fill_q  <= fill_n;
        end
    end

    // Transitions: start, grow, spill, complete, flush, freeze
    always_comb begin
        state_n = state_q;
        fill_n  = fill_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (any_take) begin
                    if (spill) begin
                        state_n = ST_PARTIAL;
                        fill_n  = CW'(1);
                    end else if (full) begin
                        state_n = ST_EMPTY;
                        fill_n  = '0;
                    end else begin
                        state_n = ST_PARTIAL;          // start
                        fill_n  = CW'(total);
                    end
                end
            end
            ST_PARTIAL: begin
                if (any_take) begin
                    if (spill) begin
                        state_n = ST_PARTIAL;          // spill
                        fill_n  = CW'(1);
                    end else if (full) begin
                        state_n = ST_EMPTY;            // complete
                        fill_n  = '0;
                    end else begin
                        state_n = ST_PARTIAL;          // grow
                        fill_n  = CW'(total);
                    end
                end else if (flush) begin
                    state_n = ST_EMPTY;                // flush
                    fill_n  = '0;
                end
            end
            default: begin
                state_n = ST_EMPTY;
                fill_n  = '0;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_mask  <= '0;
            out_addr  <= '0;
            out_color <= '0;
        end else begin
            out_vld <= emit;
            if (emit) begin
                out_mask  <= mask_n;
                out_addr  <= merged_addr;
                out_color <= merged_color;
            end
        end
    end
endmodule

// File: rtl/pvp_packer_chk.sv
module pvp_packer_chk
    import pvp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CW    = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_i,
    input logic             a_vld,
    input logic             b_vld,
    input logic             out_vld,
    input logic [LANES-1:0] out_mask,
    input logic [CW-1:0]    fill,
    input pvp_state_e       state
);
    AST_STALL_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> !out_vld);                                                   // R9
    AST_STALL_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(fill));                                              // R9
    AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_mask != '0) && (((out_mask + 1'b1) & out_mask) == '0)); // R10
    AST_EMPTY_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (fill == '0));                                   // R1
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill < CW'(LANES));                                                      // R2
    AST_SPILL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && a_vld && b_vld && (fill == CW'(LANES - 1)))
            |=> out_vld && (&out_mask) && (fill == CW'(1)));                     // R5
    AST_PARTIAL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !(&out_mask)) |-> $past(!a_vld && !b_vld && !stall_i));      // R6
endmodule

bind pix_vec_packer pvp_packer_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_i  (stall_i),
    .a_vld    (a_vld),
    .b_vld    (b_vld),
    .out_vld  (out_vld),
    .out_mask (out_mask),
    .fill     (fill_q),
    .state    (state_q)
);

// File: tb/pix_vec_packer_bench.sv
`timescale 1ns/1ps
module pix_vec_packer_bench;
    localparam int LANES = 8;
    localparam int AW    = 16;
    localparam int CLW   = 16;
    localparam int TMO   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall_i = 1'b0;
    logic a_vld = 1'b0, b_vld = 1'b0;
    logic [AW-1:0]  a_addr = '0, b_addr = '0;
    logic [CLW-1:0] a_color = '0, b_color = '0;
    logic                  out_vld;
    logic [LANES-1:0]      out_mask;
    logic [LANES*AW-1:0]   out_addr;
    logic [LANES*CLW-1:0]  out_color;

    always #2.5 clk = ~clk;

    pix_vec_packer u_pix_vec_packer (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .a_vld(a_vld), .a_addr(a_addr), .a_color(a_color),
        .b_vld(b_vld), .b_addr(b_addr), .b_color(b_color),
        .out_vld(out_vld), .out_mask(out_mask),
        .out_addr(out_addr), .out_color(out_color)
    );

    typedef struct {
        logic [LANES-1:0]     mask;
        logic [LANES*AW-1:0]  addr;
        logic [LANES*CLW-1:0] color;
        int                   stamp;
        string                req;
    } vec_t;

    vec_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seq    = 1;

    logic [LANES*AW-1:0]  m_addr  = '0;
    logic [LANES*CLW-1:0] m_color = '0;
    int m_cnt = 0;
    int m_tmr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_vec(input logic [LANES-1:0] mask, input string req);
        vec_t v;
        v.mask  = mask;
        v.addr  = m_addr;
        v.color = m_color;
        v.stamp = cyc + 1;
        v.req   = req;
        exp_q.push_back(v);
    endtask

    task automatic place(input logic [AW-1:0] ad, input logic [CLW-1:0] co, input string req);
        m_addr[m_cnt*AW +: AW]   = ad;
        m_color[m_cnt*CLW +: CLW] = co;
        m_cnt++;
        if (m_cnt == LANES) begin
            push_vec('1, req);
            m_cnt = 0;
        end
    endtask

    // Driver: applies one clock of stimulus at a falling edge and predicts the result.
    task automatic step(input bit av, input bit bv, input bit st, input string req);
        a_vld = av; b_vld = bv; stall_i = st;
        a_addr = AW'(seq);  a_color = CLW'(seq * 3 + 7);
        b_addr = AW'(seq + 1); b_color = CLW'((seq + 1) * 3 + 7);
        seq += 2;
        if (!st) begin
            if (av) place(a_addr, a_color, req);
            if (bv) place(b_addr, b_color, req);
            if (av || bv) begin
                m_tmr = TMO - 1;
            end else if (m_cnt > 0) begin
                if (m_tmr == 0) begin
                    push_vec(LANES'((1 << m_cnt) - 1), req);
                    m_cnt = 0;
                end else begin
                    m_tmr--;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, req);
    endtask

    // Monitor: compares every produced vector with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9", "unexpected vector mask", longint'(out_mask), 0);
            end else begin
                vec_t e;
                bit lane_ok;
                e = exp_q.pop_front();
                chk(cyc == e.stamp, e.req, "emit cycle", cyc, e.stamp);
                chk(out_mask == e.mask, e.req, "mask", longint'(out_mask), longint'(e.mask));
                lane_ok = 1'b1;
                for (int i = 0; i < LANES; i++) begin
                    if (e.mask[i] && ((out_addr[i*AW +: AW] != e.addr[i*AW +: AW]) ||
                                      (out_color[i*CLW +: CLW] != e.color[i*CLW +: CLW]))) begin
                        if (lane_ok)
                            chk(1'b0, {e.req, " R10"}, $sformatf("lane %0d addr", i),
                                longint'(out_addr[i*AW +: AW]), longint'(e.addr[i*AW +: AW]));
                        lane_ok = 1'b0;
                    end
                end
                if (lane_ok) chk(1'b1, {e.req, " R10"}, "lanes", 0, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run cycles", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld idle after reset", out_vld, 0);

        // R1 R2 R4: eight A-only pixels form one full vector
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, "R1 R2 R4");
        idle(2, "R2");
        // R3: paired arrivals, A in the lower lane
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0, "R3");
        idle(2, "R3");
        // R4: B alone completes the last lane
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, "R4 B-only");
        // R4: both exactly fill the last two lanes
        for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, 1'b0, "R4 pair");
        idle(2, "R4");
        // R5: overflow carries B into lane 0 of the next vector
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b0, "R5 spill");
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, "R5 carry");
        idle(3, "R5");
        // R6: partial flush after 32 idle clocks
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, "R6");
        idle(40, "R6 flush");
        // R7: late pixel restarts the countdown
        step(1'b1, 1'b1, 1'b0, "R7");
        idle(20, "R7");
        step(1'b0, 1'b1, 1'b0, "R7");
        idle(40, "R7 flush");
        // R8: nothing emitted while empty
        idle(60, "R8");
        // R9: stall with valid inputs freezes everything, then flush resumes
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, "R9");
        for (int k = 0; k < 50; k++) step(1'b1, 1'b1, 1'b1, "R9");
        idle(40, "R9 flush");
        // R9: stall while seven lanes held, then release completes normally
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, "R9");
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b0, "R9 release");
        idle(4, "R9");

        chk(exp_q.size() == 0, "R2", "pending predicted vectors", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule